// File: doc/BRIEF.md
# Edge/Level Interrupt Controller

This block collects 32 interrupt request lines and presents them to a processor as two outputs: a normal interrupt and a fast interrupt. Each line has its own configuration word that selects edge or level sensing, the output class it feeds and a 5-bit priority value. A line that becomes pending and is not masked competes in the arbiter of its class. The winner's number is latched into a code register, and the output is raised.

The processor services an interrupt by reading the code register of the class. For an edge-sensed line that read also retires the pending bit. When service is done, the processor writes the control register to re-arm the class. Re-arming drops the output for one cycle, then a new arbitration round runs. Software can also clear pending bits through the status register, and can raise a line through a trigger register.

Every access is a full 32-bit word, with a one-cycle select/write strobe. Read data is combinational during the selected cycle. Read side effects and all writes take effect at the clock edge that ends the access. The request lines are assumed synchronous to the clock.

Top module: `edge_level_intc`

## Requirements
- R1: After reset the mask at offset 0x04 reads 0xFFFFFFFF, the pending status at 0x00 reads 0, every configuration word reads 0, both code registers read 0, and irq_o and fiq_o are low.
- R2: For an edge-sensed line (configuration bit 1 = 0), a 0-to-1 change of its input sets pending bit n of offset 0x00. A line held high does not set it again. The bit stays set after the input returns to 0.
- R3: For a level-sensed line (configuration bit 1 = 1), an input rise sets its pending bit and an input fall clears it.
- R4: A write to offset 0x00 ANDs the written data into the pending bits, except that a level-sensed line whose input is currently 1 keeps its bit.
- R5: The configuration word of line n sits at offset 0x1C + 4n. Bits [6:2] hold the priority, bit 1 selects level (1) or edge (0), and bit 0 selects the fast class (1) or the normal class (0). It reads back in bits [6:0], with the other bits as 0.
- R6: Within a class, among pending lines whose mask bit is 0, the lowest priority value wins. A tie goes to the highest line number. Lines of the other class or with mask bit 1 do not compete.
- R7: When a class is armed and has a competing line, its output rises one cycle after the pending state shows the line, and the class code latches the winner. The output then stays high and the code stays frozen until control offset 0x18 is written with bit 0 (normal) or bit 1 (fast) set. That write lowers the output at the same edge and re-arms the class. The control register reads 0.
- R8: A read of offset 0x10 (normal) or 0x14 (fast) returns the latched line number. If that line is edge-sensed, its pending bit is cleared at the end of the read; a level-sensed line keeps its bit.
- R9: A write to offset 0x9C acts as an input rise on the lowest-numbered set bit of the data only. An edge-sensed line whose input is already 1 is not set. The register reads 0.
- R10: A write to offset 0x04 replaces the mask, and the new mask is used in the following arbitration without needing a re-arm.
- R11: Reads of undefined offsets or of offsets with address bits [1:0] nonzero return 0. Writes there have no effect, and writes to the code registers have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_wr is low |
| line_i | input | 32 | Interrupt request lines, active high |
| irq_o | output | 1 | Normal-class interrupt output |
| fiq_o | output | 1 | Fast-class interrupt output |

## Verification
A wrong pending bit shows at the status register at once, and at the outputs in the next cycle: a missing bit leaves irq_o or fiq_o low, and a stale bit makes the output come back one cycle after a re-arm. Priority or tie errors show as a wrong line number in the code register on the first read after the output rises. A lost arm flag shows as an output that never rises again after the control write. A wrong sensing mode shows within one cycle of an input change, or after a code read or a status write that should or should not clear a bit.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LINES  = 32;
    localparam int PRIO_W = 5;
    localparam int ID_W   = $clog2(LINES);
    localparam int AW     = 8;
    localparam int DW     = 32;
    localparam int NCLS   = 2;   // class 0 = normal, class 1 = fast

    localparam logic [AW-1:0] OFF_PEND     = 8'h00;
    localparam logic [AW-1:0] OFF_MASK     = 8'h04;
    localparam logic [AW-1:0] OFF_CODE_IRQ = 8'h10;
    localparam logic [AW-1:0] OFF_CODE_FIQ = 8'h14;
    localparam logic [AW-1:0] OFF_CTRL     = 8'h18;
    localparam logic [AW-1:0] OFF_CFG0     = 8'h1C;
    localparam logic [AW-1:0] OFF_CFG_LAST = OFF_CFG0 + AW'(4 * (LINES - 1));
    localparam logic [AW-1:0] OFF_SWTRIG   = 8'h9C;

    typedef struct packed {
        logic [LINES-1:0]              pend;
        logic [LINES-1:0]              mask;
        logic [LINES-1:0]              lvl;
        logic [LINES-1:0]              cls;
        logic [LINES-1:0]              in_prev;
        logic [LINES-1:0][PRIO_W-1:0]  prio;
        logic [NCLS-1:0]               armed;
        logic [NCLS-1:0]               outp;
        logic [NCLS-1:0][ID_W-1:0]     code;
    } intc_state_t;
endpackage

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
    parameter int N  = 32,
    parameter int PW = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]         cand_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic [IW-1:0]        win_o,
    output logic                 any_o
);
    logic [PW-1:0] best;

    // Ascending scan with <= so that equal priorities favour the higher line.
    always_comb begin
        best  = '1;
        win_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (prio_i[i] <= best)) begin
                best  = prio_i[i];
                win_o = IW'(i);
            end
        end
    end

    assign any_o = |cand_i;
endmodule

// File: rtl/intc_sense.sv
module intc_sense #(
    parameter int N = 32
) (
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] lvl_i,
    input  logic         sw_en_i,
    input  logic [N-1:0] sw_data_i,
    output logic [N-1:0] set_o,
    output logic [N-1:0] clr_o
);
    logic [N-1:0] hw_rise;
    logic [N-1:0] sw_low;

    assign hw_rise = line_i & ~prev_i;
    // isolate lowest set bit of the trigger data
    assign sw_low  = sw_en_i ? (sw_data_i & (~sw_data_i + N'(1))) : '0;
    // edge lines accept a software rise only while their input is idle
    assign set_o   = hw_rise | (sw_low & (lvl_i | ~prev_i));
    assign clr_o   = ~line_i & prev_i & lvl_i;
endmodule

// File: rtl/edge_level_intc.sv
module edge_level_intc
    import intc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [LINES-1:0] line_i,
    output logic          irq_o,
    output logic          fiq_o
);
    intc_state_t state_d, state_q;

    logic                        acc_ok, wr_en, rd_en, cfg_hit;
    logic [ID_W-1:0]             cfg_idx;
    logic                        pend_wr, mask_wr, ctrl_wr, sw_wr, code_rd;
    logic                        code_cls;
    logic [ID_W-1:0]             code_idx;
    logic [LINES-1:0]            set_v, clr_v;
    logic [NCLS-1:0][LINES-1:0]  cand;
    logic [NCLS-1:0][ID_W-1:0]   win;
    logic [NCLS-1:0]             any;

    assign acc_ok  = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr_en   = acc_ok && bus_wr;
    assign rd_en   = acc_ok && !bus_wr;
    assign cfg_hit = (bus_addr >= OFF_CFG0) && (bus_addr <= OFF_CFG_LAST);
    assign cfg_idx = ID_W'((bus_addr - OFF_CFG0) >> 2);
    assign pend_wr = wr_en && (bus_addr == OFF_PEND);
    assign mask_wr = wr_en && (bus_addr == OFF_MASK);
    assign ctrl_wr = wr_en && (bus_addr == OFF_CTRL);
    assign sw_wr   = wr_en && (bus_addr == OFF_SWTRIG);
    assign code_rd = rd_en && ((bus_addr == OFF_CODE_IRQ) || (bus_addr == OFF_CODE_FIQ));
    assign code_cls = bus_addr[2];
    assign code_idx = state_q.code[code_cls];

    intc_sense #(.N(LINES)) u_sense (
        .line_i    (line_i),
        .prev_i    (state_q.in_prev),
        .lvl_i     (state_q.lvl),
        .sw_en_i   (sw_wr),
        .sw_data_i (bus_wdata[LINES-1:0]),
        .set_o     (set_v),
        .clr_o     (clr_v)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign cand[c] = state_q.pend & ~state_q.mask &
                         ((c == 1) ? state_q.cls : ~state_q.cls);
        intc_prio_arb #(.N(LINES), .PW(PRIO_W), .IW(ID_W)) u_arb (
            .cand_i (cand[c]),
            .prio_i (state_q.prio),
            .win_o  (win[c]),
            .any_o  (any[c])
        );
    end

    always_comb begin
        state_d = state_q;
        state_d.in_prev = line_i;

        if (pend_wr)
            state_d.pend = state_q.pend &
                           (bus_wdata[LINES-1:0] | (state_q.in_prev & state_q.lvl));
        if (mask_wr)
            state_d.mask = bus_wdata[LINES-1:0];
        if (wr_en && cfg_hit) begin
            state_d.prio[cfg_idx] = bus_wdata[PRIO_W+1:2];
            state_d.lvl[cfg_idx]  = bus_wdata[1];
            state_d.cls[cfg_idx]  = bus_wdata[0];
        end
        if (code_rd && !state_q.lvl[code_idx])
            state_d.pend[code_idx] = 1'b0;

        state_d.pend = (state_d.pend & ~clr_v) | set_v;

        for (int c = 0; c < NCLS; c++) begin
            if (ctrl_wr && bus_wdata[c]) begin
                state_d.outp[c]  = 1'b0;
                state_d.armed[c] = 1'b1;
            end else if (state_q.armed[c] && any[c]) begin
                state_d.outp[c]  = 1'b1;
                state_d.armed[c] = 1'b0;
                state_d.code[c]  = win[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.mask  <= '1;
            state_q.armed <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (bus_addr == OFF_PEND)
                bus_rdata = DW'(state_q.pend);
            else if (bus_addr == OFF_MASK)
                bus_rdata = DW'(state_q.mask);
            else if (code_rd)
                bus_rdata = DW'(code_idx);
            else if (cfg_hit)
                bus_rdata = DW'({state_q.prio[cfg_idx], state_q.lvl[cfg_idx],
                                 state_q.cls[cfg_idx]});
        end
    end

    assign irq_o = state_q.outp[0];
    assign fiq_o = state_q.outp[1];

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(ctrl_wr && bus_wdata[0])) |=> irq_o);

    // R7
    fiq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[1]) |=> !fiq_o);

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(state_q.pend & ~state_q.mask & ~state_q.cls)));

    // R4
    lvl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> (($past(state_q.pend & state_q.lvl & state_q.in_prev & line_i)
                      & ~state_q.pend) == '0));

    // R3
    lvl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && |(state_q.lvl & state_q.in_prev & ~line_i)) |=>
        (($past(state_q.lvl & state_q.in_prev & ~line_i) & state_q.pend) == '0));
endmodule

// File: tb/sim_edge_level_intc.sv
module sim_edge_level_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] line_i = '0;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_level_intc u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_i(line_i), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk);
        line_i[i] = v;
    endtask

    task automatic t_reset;
        rd_chk("R1 pend", 8'h00, 32'h0);
        rd_chk("R1 mask", 8'h04, 32'hFFFF_FFFF);
        rd_chk("R1 cfg5", 8'h30, 32'h0);
        chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
        chk("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
        rd_chk("R1 code", 8'h10, 32'h0);
        rd_chk("R1 fcode", 8'h14, 32'h0);
    endtask

    task automatic t_config;
        wr(8'h40, 32'hFFFF_FFFF);
        rd_chk("R5 cfg9 all ones", 8'h40, 32'h7F);
        wr(8'h98, 32'h55);
        rd_chk("R5 cfg31", 8'h98, 32'h55);
        wr(8'h40, 32'h0);
        wr(8'h98, 32'h0);
        rd_chk("R5 cfg9 cleared", 8'h40, 32'h0);
    endtask

    task automatic t_edge;
        wr(8'h04, 32'h0);
        set_line(3, 1'b1);
        idle(2);
        rd_chk("R2 edge set", 8'h00, 32'h8);
        chk("R7 irq raised", {31'b0, irq_o}, 32'h1);
        rd_chk("R8 code line3", 8'h10, 32'd3);
        rd_chk("R8 edge ack clears", 8'h00, 32'h0);
        idle(2);
        rd_chk("R2 held high no re-pend", 8'h00, 32'h0);
        set_line(3, 1'b0);
        set_line(4, 1'b1);
        idle(1);
        set_line(4, 1'b0);
        idle(2);
        rd_chk("R2 latched after fall", 8'h00, 32'h10);
        chk("R7 irq held", {31'b0, irq_o}, 32'h1);
        rd_chk("R7 code frozen", 8'h10, 32'd3);
        rd_chk("R7 line4 kept by frozen read", 8'h00, 32'h10);
        wr(8'h18, 32'h1);
        chk("R7 ack drops irq", {31'b0, irq_o}, 32'h0);
        idle(1);
        chk("R7 re-arm raises", {31'b0, irq_o}, 32'h1);
        rd_chk("R7 new code", 8'h10, 32'd4);
        wr(8'h18, 32'h1);
        idle(2);
        chk("R7 idle after ack", {31'b0, irq_o}, 32'h0);
        rd_chk("R7 ctrl reads 0", 8'h18, 32'h0);
    endtask

    task automatic t_level;
        wr(8'h38, 32'h2);
        set_line(7, 1'b1);
        idle(2);
        rd_chk("R3 level set", 8'h00, 32'h80);
        chk("R3 irq", {31'b0, irq_o}, 32'h1);
        wr(8'h00, 32'h0);
        rd_chk("R4 level active kept", 8'h00, 32'h80);
        rd_chk("R8 level code", 8'h10, 32'd7);
        rd_chk("R8 level not cleared", 8'h00, 32'h80);
        set_line(7, 1'b0);
        idle(1);
        rd_chk("R3 level fall clears", 8'h00, 32'h0);
        wr(8'h18, 32'h1);
        idle(2);
        chk("R3 irq quiet", {31'b0, irq_o}, 32'h0);
        wr(8'h38, 32'h0);
    endtask

    task automatic t_arb;
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h24, 32'h0C);
        wr(8'h40, 32'h04);
        wr(8'h6C, 32'h04);
        wr(8'h9C, 32'h0010_0204);
        rd_chk("R9 lowest bit only", 8'h00, 32'h4);
        wr(8'h9C, 32'h0010_0200);
        wr(8'h9C, 32'h0010_0000);
        rd_chk("R9 three pending", 8'h00, 32'h0010_0204);
        chk("R6 masked no irq", {31'b0, irq_o}, 32'h0);
        wr(8'h04, 32'h0);
        idle(1);
        chk("R10 unmask raises", {31'b0, irq_o}, 32'h1);
        rd_chk("R6 tie to higher line", 8'h10, 32'd20);
        wr(8'h18, 32'h1);
        idle(1);
        rd_chk("R6 next by priority", 8'h10, 32'd9);
        wr(8'h18, 32'h1);
        idle(1);
        rd_chk("R6 last", 8'h10, 32'd2);
        wr(8'h18, 32'h1);
        idle(2);
        chk("R6 all served", {31'b0, irq_o}, 32'h0);
        rd_chk("R6 pend empty", 8'h00, 32'h0);
        rd_chk("R9 trig reads 0", 8'h9C, 32'h0);
    endtask

    task automatic t_fiq;
        wr(8'h48, 32'h1);
        set_line(11, 1'b1);
        idle(2);
        chk("R6 fiq raised", {31'b0, fiq_o}, 32'h1);
        chk("R6 irq untouched", {31'b0, irq_o}, 32'h0);
        rd_chk("R8 fiq code", 8'h14, 32'd11);
        rd_chk("R8 fiq edge clear", 8'h00, 32'h0);
        wr(8'h9C, 32'h800);
        rd_chk("R9 edge busy blocks trig", 8'h00, 32'h0);
        set_line(11, 1'b0);
        idle(1);
        wr(8'h9C, 32'h800);
        rd_chk("R9 trig sets idle line", 8'h00, 32'h800);
        wr(8'h18, 32'h2);
        chk("R7 fiq ack drops", {31'b0, fiq_o}, 32'h0);
        idle(1);
        chk("R7 fiq re-raised", {31'b0, fiq_o}, 32'h1);
        rd_chk("R8 fiq code again", 8'h14, 32'd11);
        wr(8'h18, 32'h2);
        idle(2);
        chk("R7 fiq quiet", {31'b0, fiq_o}, 32'h0);
        chk("R6 irq still quiet", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_undef;
        wr(8'h08, 32'hFFFF);
        rd_chk("R11 undef reads 0", 8'h08, 32'h0);
        wr(8'h05, 32'hFFFF_FFFF);
        rd_chk("R11 misaligned write ignored", 8'h04, 32'h0);
        rd_chk("R11 misaligned read", 8'h05, 32'h0);
        wr(8'h10, 32'h1F);
        rd_chk("R11 code write ignored", 8'h10, 32'd2);
        rd_chk("R11 beyond map", 8'hA0, 32'h0);
        wr(8'h9C, 32'h40);
        rd_chk("R4 edge pend before clear", 8'h00, 32'h40);
        wr(8'h00, 32'hFFFF_FFBF);
        rd_chk("R4 edge bit cleared", 8'h00, 32'h0);
        wr(8'h18, 32'h3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_edge();
        t_level();
        t_arb();
        t_fiq();
        t_undef();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule